// File: doc/BRIEF.md
# Scrambling Key Request Tracker

This block owns the key and nonce that a memory scrambler uses. Software asks for a new key with a one-cycle renew pulse. The block then fetches a key, a nonce and a seed-quality flag from a key provider that runs on its own clock. It uses a four-phase request/acknowledge handshake, and each direction of that handshake crosses the clock boundary through a two-flop synchronizer. Until the fetched values arrive, memory traffic is held off through the key-valid output.

After reset the key and nonce hold build-time default constants, and key-valid is high at once. The memory can therefore be used straight away without a first fetch.

Two escalation sources, an encoded life-cycle input and an internal fault line, merge into one local escalation. Local escalation is sticky until reset. It puts the defaults back into the key and nonce, clears the seed flag, withholds key-valid and blocks any payload that arrives later.

Top module: `kreq_top`

## Requirements
- R1: After reset, key_o and nonce_o equal the KeyDefault and NonceDefault parameters, seed_ok_o is 0, key_valid_o is 1, pending_o is 0 and kp_req_o is 0.
- R2: A renew_i pulse that is accepted raises pending_o on the next clk_i edge. key_valid_o is 0 from that edge until the request completes.
- R3: The request reaches the provider as kp_req_o through two clk_kp_i flops, so kp_req_o is still 0 half a clk_i cycle after pending_o rises. The acknowledge returns through two clk_i flops.
- R4: On the clk_i edge where the synchronized acknowledge is seen while pending, kp_key_i, kp_nonce_i and kp_seed_ok_i are captured into key_o, nonce_o and seed_ok_o, and pending_o falls.
- R5: A renew_i pulse is ignored while a request is pending, and also until the synchronized acknowledge has dropped again. Exactly one provider handshake takes place per accepted request.
- R6: Local escalation is asserted when lc_esc_i differs from 4'b0101 (the only off code) or when fault_i is 1.
- R7: Local escalation restores the default key and nonce, clears seed_ok_o and forces key_valid_o to 0. This state is kept until reset, even after both sources return to inactive.
- R8: A payload whose acknowledge arrives after escalation was raised during the pending request is not captured. The handshake still completes and pending_o still falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Async active-low reset, block domain |
| clk_kp_i | input | 1 | Key provider clock |
| rst_kp_ni | input | 1 | Async active-low reset, provider domain |
| renew_i | input | 1 | One-cycle request for a fresh key |
| lc_esc_i | input | 4 | Encoded life-cycle escalation, 4'b0101 means off |
| fault_i | input | 1 | Internal fault escalation |
| kp_req_o | output | 1 | Request level, provider domain |
| kp_ack_i | input | 1 | Acknowledge level from provider |
| kp_key_i | input | KeyW | Key payload, stable while ack high |
| kp_nonce_i | input | NonceW | Nonce payload, stable while ack high |
| kp_seed_ok_i | input | 1 | Payload came from a valid seed |
| key_o | output | KeyW | Current scrambling key |
| nonce_o | output | NonceW | Current scrambling nonce |
| seed_ok_o | output | 1 | Current key came from a valid seed |
| key_valid_o | output | 1 | Memory transactions permitted |
| pending_o | output | 1 | A key request is outstanding |

## Verification
An escalation and a payload capture can target the same key registers in one window. The bench provokes this by pulsing fault_i for a single cycle while a request is pending, before the provider acknowledges, and then letting the handshake finish. It is judged by checking that the key, nonce and seed flag stay at their defaults, that pending still clears, and that key-valid stays low. The life-cycle input is swept over all sixteen codes, each after a fresh reset, to confirm that only the off code leaves key-valid high.

// File: rtl/kreq_pkg.sv
package kreq_pkg;
  localparam int unsigned LcW = 4;
  localparam logic [LcW-1:0] LcOff = 4'b0101;

  typedef enum logic [1:0] {
    REQ_IDLE,
    REQ_WAIT_ACK,
    REQ_WAIT_DROP
  } req_state_e;
endpackage

// File: rtl/kreq_sync2.sv
module kreq_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/kreq_fsm.sv
module kreq_fsm
  import kreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic renew_i,
  input  logic ack_sync_i,
  output logic req_o,
  output logic load_o
);
  req_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    unique case (state_q)
      REQ_IDLE: begin
        if (renew_i && !ack_sync_i) state_d = REQ_WAIT_ACK;
      end
      REQ_WAIT_ACK: begin
        if (ack_sync_i) begin
          load_o  = 1'b1;
          state_d = REQ_WAIT_DROP;
        end
      end
      REQ_WAIT_DROP: begin
        if (!ack_sync_i) state_d = REQ_IDLE;
      end
      default: state_d = REQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= REQ_IDLE;
    else         state_q <= state_d;
  end

  assign req_o = (state_q == REQ_WAIT_ACK);

  AST_ACK_ENDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_sync_i) |=> !req_o); // R4

  AST_REQ_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(renew_i)); // R5

  AST_NO_REARM_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && ack_sync_i) |=> !req_o); // R5
endmodule

// File: rtl/kreq_store.sv
module kreq_store #(
  parameter int unsigned      KeyW         = 64,
  parameter int unsigned      NonceW       = 32,
  parameter logic [KeyW-1:0]  KeyDefault   = '0,
  parameter logic [NonceW-1:0] NonceDefault = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              esc_i,
  input  logic [KeyW-1:0]   key_i,
  input  logic [NonceW-1:0] nonce_i,
  input  logic              seed_ok_i,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o,
  output logic              seed_ok_o
);
  logic [KeyW-1:0]   key_q, key_d;
  logic [NonceW-1:0] nonce_q, nonce_d;
  logic              seed_q, seed_d;
  logic              en;

  assign en = esc_i | load_i;

  always_comb begin
    if (esc_i) begin
      key_d   = KeyDefault;
      nonce_d = NonceDefault;
      seed_d  = 1'b0;
    end else begin
      key_d   = key_i;
      nonce_d = nonce_i;
      seed_d  = seed_ok_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= KeyDefault;
      nonce_q <= NonceDefault;
      seed_q  <= 1'b0;
    end else if (en) begin
      key_q   <= key_d;
      nonce_q <= nonce_d;
      seed_q  <= seed_d;
    end
  end

  assign key_o     = key_q;
  assign nonce_o   = nonce_q;
  assign seed_ok_o = seed_q;

  AST_ESC_SCRAPS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> (key_q == KeyDefault && nonce_q == NonceDefault && !seed_q)); // R7

  AST_LOAD_TAKES_PAYLOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !esc_i) |=> (key_q == $past(key_i) && seed_q == $past(seed_ok_i))); // R4

  AST_HOLD_WHEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !esc_i) |=> $stable(key_q)); // R5
endmodule

// File: rtl/kreq_top.sv
module kreq_top
  import kreq_pkg::*;
#(
  parameter int unsigned       KeyW         = 64,
  parameter int unsigned       NonceW       = 32,
  parameter logic [KeyW-1:0]   KeyDefault   = 64'hA5A5_0F0F_1234_5678,
  parameter logic [NonceW-1:0] NonceDefault = 32'hC0DE_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_kp_i,
  input  logic              rst_kp_ni,
  input  logic              renew_i,
  input  logic [LcW-1:0]    lc_esc_i,
  input  logic              fault_i,
  output logic              kp_req_o,
  input  logic              kp_ack_i,
  input  logic [KeyW-1:0]   kp_key_i,
  input  logic [NonceW-1:0] kp_nonce_i,
  input  logic              kp_seed_ok_i,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o,
  output logic              seed_ok_o,
  output logic              key_valid_o,
  output logic              pending_o
);
  logic esc_raw, esc_q, esc_d, local_esc;
  logic req, ack_sync, load;

  // Escalation merge: sticky until reset
  assign esc_raw   = (lc_esc_i != LcOff) | fault_i;
  assign esc_d     = esc_q | esc_raw;
  assign local_esc = esc_raw | esc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) esc_q <= 1'b0;
    else         esc_q <= esc_d;
  end

  kreq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .renew_i    (renew_i),
    .ack_sync_i (ack_sync),
    .req_o      (req),
    .load_o     (load)
  );

  kreq_sync2 #(.W(1)) u_req_sync (
    .clk_i  (clk_kp_i),
    .rst_ni (rst_kp_ni),
    .d_i    (req),
    .q_o    (kp_req_o)
  );

  kreq_sync2 #(.W(1)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (kp_ack_i),
    .q_o    (ack_sync)
  );

  kreq_store #(
    .KeyW         (KeyW),
    .NonceW       (NonceW),
    .KeyDefault   (KeyDefault),
    .NonceDefault (NonceDefault)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .esc_i     (local_esc),
    .key_i     (kp_key_i),
    .nonce_i   (kp_nonce_i),
    .seed_ok_i (kp_seed_ok_i),
    .key_o     (key_o),
    .nonce_o   (nonce_o),
    .seed_ok_o (seed_ok_o)
  );

  assign pending_o   = req;
  assign key_valid_o = !req && !local_esc;

  AST_ESC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_q |=> esc_q); // R7

  AST_LC_CODE_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_esc_i != LcOff) |=> (esc_q && !seed_ok_o)); // R6

  AST_FAULT_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !key_valid_o); // R6
endmodule

// File: tb/kreq_top_bench.sv
`timescale 1ns/1ps
module kreq_top_bench;
  localparam logic [63:0] KDEF = 64'hA5A5_0F0F_1234_5678;
  localparam logic [31:0] NDEF = 32'hC0DE_0001;
  localparam logic [3:0]  OFF  = 4'b0101;

  logic clk = 0, clk_kp = 0, rst_n = 0, rst_kp_n = 0;
  logic renew = 0, fault = 0, ack = 0, seed_in = 0;
  logic [3:0] lc = OFF;
  logic [63:0] key_in = '0;
  logic [31:0] nonce_in = '0;
  logic kp_req, seed_ok, key_valid, pending;
  logic [63:0] key;
  logic [31:0] nonce;
  int checks = 0, errors = 0, hs_cnt = 0;
  logic [63:0] prov_key = '0;
  logic [31:0] prov_nonce = '0;
  logic prov_seed = 0;

  always #2.5 clk = ~clk;
  always #3.3 clk_kp = ~clk_kp;

  kreq_top #(.KeyW(64), .NonceW(32), .KeyDefault(KDEF), .NonceDefault(NDEF)) u_kreq_top (
    .clk_i(clk), .rst_ni(rst_n), .clk_kp_i(clk_kp), .rst_kp_ni(rst_kp_n),
    .renew_i(renew), .lc_esc_i(lc), .fault_i(fault),
    .kp_req_o(kp_req), .kp_ack_i(ack), .kp_key_i(key_in), .kp_nonce_i(nonce_in),
    .kp_seed_ok_i(seed_in), .key_o(key), .nonce_o(nonce), .seed_ok_o(seed_ok),
    .key_valid_o(key_valid), .pending_o(pending)
  );

  // provider model in its own domain
  initial begin
    forever begin
      @(negedge clk_kp);
      if (kp_req && !ack) begin
        key_in = prov_key; nonce_in = prov_nonce; seed_in = prov_seed;
        ack = 1; hs_cnt++;
      end else if (!kp_req && ack) begin
        ack = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; rst_kp_n = 0; lc = OFF; fault = 0; renew = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; rst_kp_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_renew();
    renew = 1; @(negedge clk); renew = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && (pending || kp_req || ack); i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic fetch(input logic [63:0] k, input logic [31:0] n, input logic s);
    prov_key = k; prov_nonce = n; prov_seed = s;
    pulse_renew();
    chk(pending == 1, "R2", 64'(pending), 64'd1);
    chk(key_valid == 0, "R2", 64'(key_valid), 64'd0);
    chk(kp_req == 0, "R3", 64'(kp_req), 64'd0);
    wait_idle();
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h0;
    do_reset();
    // R1
    chk(key == KDEF, "R1", key, KDEF);
    chk(nonce == NDEF, "R1", 64'(nonce), 64'(NDEF));
    chk(seed_ok == 0, "R1", 64'(seed_ok), 0);
    chk(key_valid == 1, "R1", 64'(key_valid), 1);
    chk(pending == 0 && kp_req == 0, "R1", 64'(pending), 0);

    // R4: normal fetches with several payloads
    for (int i = 0; i < 4; i++) begin
      logic [63:0] k = 64'h1111_2222_3333_4444 * (i + 3);
      logic [31:0] n = 32'h0BAD_0000 + 32'(i);
      h0 = hs_cnt;
      fetch(k, n, i[0]);
      chk(key == k, "R4", key, k);
      chk(nonce == n, "R4", 64'(nonce), 64'(n));
      chk(seed_ok == i[0], "R4", 64'(seed_ok), 64'(i[0]));
      chk(key_valid == 1 && pending == 0, "R4", 64'(key_valid), 1);
      chk(hs_cnt == h0 + 1, "R3", 64'(hs_cnt - h0), 1);
    end

    // R5: renew while pending and while ack still synchronized high
    h0 = hs_cnt;
    prov_key = 64'hFEED_0000_0000_0001; prov_nonce = 32'h1; prov_seed = 1;
    pulse_renew();
    repeat (3) @(negedge clk);
    pulse_renew();
    for (int i = 0; i < 200 && pending; i++) @(negedge clk);
    prov_key = 64'hDEAD_0000_0000_0002;
    pulse_renew();
    chk(pending == 0, "R5", 64'(pending), 0);
    wait_idle();
    chk(hs_cnt == h0 + 1, "R5", 64'(hs_cnt - h0), 1);
    chk(key == 64'hFEED_0000_0000_0001, "R5", key, 64'hFEED_0000_0000_0001);
    chk(key_valid == 1, "R5", 64'(key_valid), 1);

    // R7: escalation after a loaded key, sticky
    lc = 4'b1010;
    @(negedge clk); @(negedge clk);
    chk(key == KDEF && nonce == NDEF, "R7", key, KDEF);
    chk(seed_ok == 0, "R7", 64'(seed_ok), 0);
    chk(key_valid == 0, "R7", 64'(key_valid), 0);
    lc = OFF;
    repeat (3) @(negedge clk);
    chk(key_valid == 0, "R7", 64'(key_valid), 0);

    // R6: full sweep over life-cycle codes
    for (int c = 0; c < 16; c++) begin
      do_reset();
      lc = 4'(c);
      @(negedge clk); @(negedge clk);
      chk(key_valid == (4'(c) == OFF), "R6", 64'(key_valid), 64'(4'(c) == OFF));
      lc = OFF;
      @(negedge clk);
      chk(key_valid == (4'(c) == OFF), "R7", 64'(key_valid), 64'(4'(c) == OFF));
    end

    // R6: fault line alone
    do_reset();
    fault = 1; @(negedge clk); fault = 0; @(negedge clk);
    chk(key_valid == 0, "R6", 64'(key_valid), 0);

    // R8: escalation pulse while pending, then ack arrives
    do_reset();
    fetch(64'h0123_4567_89AB_CDEF, 32'h5555_AAAA, 1);
    chk(key == 64'h0123_4567_89AB_CDEF, "R4", key, 64'h0123_4567_89AB_CDEF);
    prov_key = 64'h7777_7777_7777_7777; prov_nonce = 32'h7; prov_seed = 1;
    pulse_renew();
    fault = 1; @(negedge clk); fault = 0;
    wait_idle();
    chk(pending == 0, "R8", 64'(pending), 0);
    chk(key == KDEF, "R8", key, KDEF);
    chk(nonce == NDEF, "R8", 64'(nonce), 64'(NDEF));
    chk(seed_ok == 0, "R8", 64'(seed_ok), 0);
    chk(key_valid == 0, "R8", 64'(key_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule